// File: doc/BRIEF.md
# Stretch-and-Shrink Period Sequencer

This controller drives repeated passes of one vector set through a device on a tester in order to find the first vector that cannot run at the design clock period. For each vector index that the pattern engine presents, it says combinationally whether that vector runs at the short design period or at a relaxed period known to pass. The vectors that are shortened are called the shrink set. After each pass the pattern engine returns pass or fail together with a done strobe, and the controller moves the shrink set on. When the search ends it reports the index of the culprit vector, or it reports that the set passed with no failure.

Four search strategies are supported. Ripple moves a single shortened vector forward. Domino grows a shortened prefix. Reverse starts fully shortened and relaxes vectors from the top down. Bisection halves the window that still holds the failure point. The shrink set is always a contiguous window of indices, so it is held as two index registers and needs no per-vector storage.

Top module: `period_sequencer`

## Requirements
- R1: After reset busy_o, done_o, found_o, run_start_o and use_short_o are all 0.
- R2: use_short_o is 1 only while a pass is in progress and vec_idx_i lies in the current shrink set. In every other case, including idle and done, it is 0 and the vector runs relaxed.
- R3: A start_i pulse taken while idle or done makes run_start_o high for exactly one cycle in the next cycle. Each later pass begins with one further one-cycle pulse.
- R4: Mode 0 (ripple) shortens exactly one vector per pass, starting at index 0. A pass moves it to the next index. A fail ends the search and reports that index.
- R5: Mode 1 (domino) shortens the prefix 0..p, starting with p=0. A pass extends p by one. A fail reports p.
- R6: Mode 2 (reverse) starts with all vectors 0..last shortened and relaxes the top vector after each fail. The first pass reports the index just above the prefix that passed. A fail with only vector 0 shortened reports 0.
- R7: Mode 3 (bisection) first runs the full prefix. If that fails, it runs the midpoint prefix of the remaining range on each pass and reports the lowest index whose prefix fails. It needs at most 1+ceil(log2(count)) passes.
- R8: If no pass fails before the search is exhausted, the block ends with done_o=1 and found_o=0.
- R9: mode_i and last_vec_i are sampled only when a search starts. A start_i or a change of those inputs during a search does not alter its result.
- R10: run_done_i is acted on only while a pass is pending. A strobe while done leaves done_o, found_o and fail_idx_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a new search |
| mode_i | input | 2 | Strategy: 0 ripple, 1 domino, 2 reverse, 3 bisection |
| last_vec_i | input | VEC_W | Highest vector index (count minus one) |
| vec_idx_i | input | VEC_W | Index of the vector being applied |
| run_done_i | input | 1 | Pattern engine finished a pass |
| run_pass_i | input | 1 | Pass result, valid with run_done_i |
| use_short_o | output | 1 | 1: design period, 0: relaxed period |
| run_start_o | output | 1 | One-cycle request to begin a pass |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | Search finished |
| found_o | output | 1 | A failing vector was identified |
| fail_idx_o | output | VEC_W | Index of the failing vector |

## Verification
A new start_i and the end of a pass can occur while a search is live. A start request and a change of mode and vector count are injected while the first pass of a ripple search is still pending. The search must still end with the same index and the same number of passes as the undisturbed run. A done strobe after completion is also driven, and the reported result must hold. A behavioural device model in the bench fails whenever a chosen vector is shortened. Each pass's shrink set is rebuilt from use_short_o and checked for shape against the strategy.

// File: rtl/sps_pkg.sv
package sps_pkg;
  typedef enum logic [1:0] {
    M_RIPPLE  = 2'd0,
    M_DOMINO  = 2'd1,
    M_REVERSE = 2'd2,
    M_BISECT  = 2'd3
  } srch_mode_e;

  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_LAUNCH = 2'd1,
    S_WAIT   = 2'd2,
    S_DONE   = 2'd3
  } sps_state_e;
endpackage

// File: rtl/sps_window.sv
module sps_window #(
  parameter int VEC_W = 8
) (
  input  logic             en,
  input  logic [VEC_W-1:0] idx,
  input  logic [VEC_W-1:0] lo,
  input  logic [VEC_W-1:0] hi,
  output logic             hit
);
  function automatic logic in_win(input logic [VEC_W-1:0] i,
                                  input logic [VEC_W-1:0] a,
                                  input logic [VEC_W-1:0] b);
    return (i >= a) && (i <= b);
  endfunction

  assign hit = en && in_win(idx, lo, hi);
endmodule

// File: rtl/sps_step.sv
module sps_step
  import sps_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  srch_mode_e       mode,
  input  logic             pass,
  input  logic             probe,
  input  logic [VEC_W-1:0] last,
  input  logic [VEC_W-1:0] lo,
  input  logic [VEC_W-1:0] hi,
  input  logic [VEC_W-1:0] blo,
  input  logic [VEC_W-1:0] bhi,
  output logic             stop,
  output logic             found,
  output logic [VEC_W-1:0] fidx,
  output logic [VEC_W-1:0] nlo,
  output logic [VEC_W-1:0] nhi,
  output logic [VEC_W-1:0] nblo,
  output logic [VEC_W-1:0] nbhi,
  output logic             nprobe
);
  function automatic logic [VEC_W-1:0] mid(input logic [VEC_W-1:0] a,
                                           input logic [VEC_W-1:0] b);
    logic [VEC_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[VEC_W:1];
  endfunction

  logic [VEC_W-1:0] lo2, hi2;

  always_comb begin
    stop   = 1'b0;
    found  = 1'b0;
    fidx   = hi;
    nlo    = lo;
    nhi    = hi;
    nblo   = blo;
    nbhi   = bhi;
    nprobe = probe;
    lo2    = pass ? hi + 1'b1 : blo;
    hi2    = pass ? bhi : hi;
    case (mode)
      M_RIPPLE, M_DOMINO: begin
        if (!pass) begin
          stop  = 1'b1;
          found = 1'b1;
        end else if (hi == last) begin
          stop = 1'b1;
        end else begin
          nhi = hi + 1'b1;
          if (mode == M_RIPPLE) nlo = hi + 1'b1;
        end
      end
      M_REVERSE: begin
        if (pass) begin
          stop = 1'b1;
          if (hi != last) begin
            found = 1'b1;
            fidx  = hi + 1'b1;
          end
        end else if (hi == '0) begin
          stop  = 1'b1;
          found = 1'b1;
        end else begin
          nhi = hi - 1'b1;
        end
      end
      default: begin
        if (probe) begin
          if (pass) begin
            stop = 1'b1;
          end else if (last == '0) begin
            stop  = 1'b1;
            found = 1'b1;
            fidx  = '0;
          end else begin
            nprobe = 1'b0;
            nblo   = '0;
            nbhi   = last;
            nhi    = mid('0, last);
          end
        end else if (lo2 == hi2) begin
          stop  = 1'b1;
          found = 1'b1;
          fidx  = lo2;
        end else begin
          nblo = lo2;
          nbhi = hi2;
          nhi  = mid(lo2, hi2);
        end
      end
    endcase
  end
endmodule

// File: rtl/period_sequencer.sv
module period_sequencer
  import sps_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       mode_i,
  input  logic [VEC_W-1:0] last_vec_i,
  input  logic [VEC_W-1:0] vec_idx_i,
  input  logic             run_done_i,
  input  logic             run_pass_i,
  output logic             use_short_o,
  output logic             run_start_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             found_o,
  output logic [VEC_W-1:0] fail_idx_o
);
  sps_state_e       st;
  srch_mode_e       mode_q, mode_in;
  logic [VEC_W-1:0] last_q, sh_lo, sh_hi, b_lo, b_hi;
  logic             probe_q;

  logic             s_stop, s_found, s_probe;
  logic [VEC_W-1:0] s_fidx, s_lo, s_hi, s_blo, s_bhi;

  logic             pass_end;
  logic             idle_like;

  assign mode_in   = srch_mode_e'(mode_i);
  assign pass_end  = (st == S_WAIT) && run_done_i;
  assign idle_like = (st == S_IDLE) || (st == S_DONE);

  sps_step #(.VEC_W(VEC_W)) u_step (
    .mode(mode_q), .pass(run_pass_i), .probe(probe_q), .last(last_q),
    .lo(sh_lo), .hi(sh_hi), .blo(b_lo), .bhi(b_hi),
    .stop(s_stop), .found(s_found), .fidx(s_fidx),
    .nlo(s_lo), .nhi(s_hi), .nblo(s_blo), .nbhi(s_bhi), .nprobe(s_probe)
  );

  sps_window #(.VEC_W(VEC_W)) u_win (
    .en(st == S_WAIT), .idx(vec_idx_i), .lo(sh_lo), .hi(sh_hi), .hit(use_short_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      mode_q     <= M_RIPPLE;
      last_q     <= '0;
      sh_lo      <= '0;
      sh_hi      <= '0;
      b_lo       <= '0;
      b_hi       <= '0;
      probe_q    <= 1'b0;
      found_o    <= 1'b0;
      fail_idx_o <= '0;
    end else begin
      case (st)
        S_LAUNCH: st <= S_WAIT;
        S_WAIT: begin
          if (run_done_i) begin
            if (s_stop) begin
              st         <= S_DONE;
              found_o    <= s_found;
              fail_idx_o <= s_found ? s_fidx : '0;
            end else begin
              st      <= S_LAUNCH;
              sh_lo   <= s_lo;
              sh_hi   <= s_hi;
              b_lo    <= s_blo;
              b_hi    <= s_bhi;
              probe_q <= s_probe;
            end
          end
        end
        default: begin
          if (start_i) begin
            st         <= S_LAUNCH;
            mode_q     <= mode_in;
            last_q     <= last_vec_i;
            sh_lo      <= '0;
            sh_hi      <= (mode_in == M_RIPPLE || mode_in == M_DOMINO) ? '0 : last_vec_i;
            b_lo       <= '0;
            b_hi       <= last_vec_i;
            probe_q    <= (mode_in == M_BISECT);
            found_o    <= 1'b0;
            fail_idx_o <= '0;
          end
        end
      endcase
    end
  end

  assign run_start_o = (st == S_LAUNCH);
  assign busy_o      = (st == S_LAUNCH) || (st == S_WAIT);
  assign done_o      = (st == S_DONE);

  // R3: a pass request never lasts beyond one cycle
  a_r3_single_launch: assert property (@(posedge clk) disable iff (!rst_n)
    run_start_o |=> !run_start_o);

  // R2: relaxed period whenever no pass is pending
  a_r2_relaxed_outside: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !use_short_o);

  // R4: ripple keeps a single shortened vector
  a_r4_ripple_single: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && mode_q == M_RIPPLE) |-> (sh_lo == sh_hi));

  // R5: prefix-based strategies always anchor the window at index 0
  a_r5_prefix_anchor: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && mode_q != M_RIPPLE) |-> (sh_lo == '0));

  // R9: sampled settings and window hold while a pass is pending
  a_r9_hold_settings: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && !pass_end) |=> ($stable(mode_q) && $stable(last_q) &&
                                     $stable(sh_lo) && $stable(sh_hi)));

  // R10: result holds in done until a new start
  a_r10_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> (done_o && $stable(fail_idx_o) && $stable(found_o)));

  // R4: a reported index lies inside the vector set
  a_r4_index_range: assert property (@(posedge clk) disable iff (!rst_n)
    (found_o && idle_like) |-> (fail_idx_o <= last_q));
endmodule

// File: tb/period_sequencer_bench.sv
module period_sequencer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [1:0] mode_i = 2'd0;
  logic [7:0] last_i = 8'd0;
  logic [7:0] vec_idx_i = 8'd0;
  logic       run_done_i = 1'b0;
  logic       run_pass_i = 1'b0;
  logic       use_short_o, run_start_o, busy_o, done_o, found_o;
  logic [7:0] fail_idx_o;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  period_sequencer u_period_sequencer (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .last_vec_i(last_i), .vec_idx_i(vec_idx_i), .run_done_i(run_done_i),
    .run_pass_i(run_pass_i), .use_short_o(use_short_o), .run_start_o(run_start_o),
    .busy_o(busy_o), .done_o(done_o), .found_o(found_o), .fail_idx_o(fail_idx_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_runs(input int md, input int last, input int k);
    if (md <= 1) return (k >= 0) ? k + 1 : last + 1;
    if (md == 2) return (k < 0) ? 1 : (k == 0) ? last + 1 : last - k + 2;
    return -1;
  endfunction

  // Device model: fails whenever vector k is shortened (k<0: never fails)
  task automatic search(input int md, input int last, input int k,
                        input bit perturb, input string tag);
    int runs = 0;
    bit shape_ok = 1'b1;
    bit [255:0] shv;
    @(negedge clk);
    mode_i = 2'(md); last_i = 8'(last); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(run_start_o == 1'b1, {tag, " R3 launch after start"}, run_start_o, 1);
    while (!done_o) begin
      if (run_start_o) begin
        runs++;
        @(negedge clk);
        if (runs == 1) chk(run_start_o == 1'b0, {tag, " R3 one-cycle launch"}, run_start_o, 0);
        shv = '0;
        for (int v = 0; v <= last; v++) begin
          vec_idx_i = 8'(v);
          #1;
          shv[v] = use_short_o;
          @(negedge clk);
        end
        if (md == 0) begin
          if ($countones(shv) != 1) shape_ok = 1'b0;
        end else begin
          if (!shv[0]) shape_ok = 1'b0;
          for (int v = 1; v <= last; v++)
            if (shv[v] && !shv[v-1]) shape_ok = 1'b0;
        end
        if (perturb && runs == 1) begin
          mode_i = 2'(md + 1); last_i = 8'(last - 1); start_i = 1'b1;
          @(negedge clk);
          start_i = 1'b0;
        end
        run_pass_i = (k < 0) || !shv[k];
        run_done_i = 1'b1;
        @(negedge clk);
        run_done_i = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
    chk(shape_ok, {tag, " R2 shrink set shape"}, shape_ok, 1);
    chk(found_o == (k >= 0), {tag, " found flag (R8 when none)"}, found_o, k >= 0);
    if (k >= 0) chk(fail_idx_o == 8'(k), {tag, " failing index"}, fail_idx_o, k);
    if (md == 3) chk(runs <= 5, {tag, " R7 pass count bound"}, runs, 5);
    else chk(runs == exp_runs(md, last, k), {tag, " pass count"}, runs, exp_runs(md, last, k));
    vec_idx_i = 8'd0;
    #1;
    chk(use_short_o == 1'b0, {tag, " R2 relaxed when done"}, use_short_o, 0);
  endtask

  task automatic t_reset();
    #1;
    chk(!busy_o && !done_o && !found_o && !run_start_o && !use_short_o,
        "R1 reset state", {busy_o, done_o, found_o, run_start_o, use_short_o}, 0);
  endtask

  task automatic t_modes();
    search(0, 9, 6, 1'b0, "R4 ripple k=6");
    search(0, 9, 0, 1'b0, "R4 ripple k=0");
    search(1, 9, 6, 1'b0, "R5 domino k=6");
    search(1, 9, 9, 1'b0, "R5 domino k=last");
    search(2, 9, 6, 1'b0, "R6 reverse k=6");
    search(2, 9, 0, 1'b0, "R6 reverse k=0");
    search(3, 9, 6, 1'b0, "R7 bisect k=6");
    search(3, 9, 0, 1'b0, "R7 bisect k=0");
    search(3, 12, 12, 1'b0, "R7 bisect k=last");
  endtask

  task automatic t_clean();
    search(0, 5, -1, 1'b0, "R8 ripple none");
    search(1, 5, -1, 1'b0, "R8 domino none");
    search(2, 5, -1, 1'b0, "R8 reverse none");
    search(3, 5, -1, 1'b0, "R8 bisect none");
  endtask

  task automatic t_sample_hold();
    search(0, 9, 4, 1'b1, "R9 ripple disturbed");
  endtask

  task automatic t_late_done();
    search(1, 7, 3, 1'b0, "R10 setup");
    @(negedge clk);
    run_pass_i = 1'b0; run_done_i = 1'b1;
    @(negedge clk);
    run_done_i = 1'b0;
    @(negedge clk);
    chk(done_o && found_o && fail_idx_o == 8'd3, "R10 stray done ignored",
        fail_idx_o, 3);
    chk(!run_start_o && !busy_o, "R10 no new pass", busy_o, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_modes();
    t_clean();
    t_sample_hold();
    t_late_done();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule